// File: doc/BRIEF.md
# Sectored Write-Back Stack Cache

The block is a small direct-mapped data cache that holds stack traffic only. Its processor side takes word-addressed loads and stores with byte enables. Its memory side moves one 32-bit word per transaction and is used for sector fills and for write-backs of dirty words. The cache is write-back, so memory sees stored data only when a line is evicted or when a flush removes the line.

The default capacity is 4 KiB. Each line holds 32 bytes, split into eight single-word sectors. Each sector has its own valid bit and its own dirty bit. A store that misses can therefore claim a line and mark only the written word, with no fetch from memory. A load fetches only the word it needs.

The tag does not hold a page number. It holds the 3-bit index of the stack-TLB entry that maps the access. The cache spans exactly one page, so no offset bits are needed above the line index. When the TLB replaces an entry, the cache is told that index. It scans every line, writes back the dirty words of each line carrying that index, and then invalidates the line.

A full-word store completes in the cycle it is presented. A store with fewer than four byte enables reads the old word, merges in the new bytes, and writes the result one cycle later. Each stored word keeps a byte-parity check code. The code is recomputed on every write, and a mismatch on a load raises an error flag.

Top module: `stk_wb_cache`

## Requirements
- R1: Stores never drive a memory write by themselves. Memory is written only while a conflicting line is being evicted or a flush is running, and a word is never dirty unless it is also valid.
- R2: A store with all four byte enables set, to a line that is empty or already carries the request's TLB index, asserts ready in the cycle it is presented. It never causes a memory read.
- R3: A store with some byte enables clear, to a valid word, asserts ready exactly one cycle after it is presented (one stall cycle). The word then holds the new byte in each lane whose enable is set and the old byte in every other lane. Enable bit i covers data bits 8i+7 down to 8i.
- R4: A store miss allocates the line and makes only the written word valid and dirty. A later load of a neighbouring word in that line performs exactly one memory read.
- R5: A load of an invalid word, in a line that is empty or carries the request's TLB index, reads exactly that one word from memory. It then returns the data, with ready high in the fourth cycle of the request.
- R6: Word address bits [4:2] select the word and bits [11:5] select the line. An access whose TLB index differs from a valid line's tag first writes back each dirty word of that line exactly once, at its own address. It then invalidates the line and goes on to serve the request. The memory request stays high, with address and direction unchanged, until it is acknowledged.
- R7: A flush for a TLB index writes back every dirty word of every line tagged with that index and invalidates those lines. Lines with other tags keep their contents and need no refetch. The flush-done output is high for a single cycle at the end.
- R8: A load of a valid word returns the most recently stored value with ready high in the cycle it is presented, and the error flag stays low.
- R9: Ready stays low whenever the cache is issuing a memory request or running a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_req | input | 1 | Processor request, held until ready |
| p_we | input | 1 | 1 = store, 0 = load |
| p_be | input | 4 | Byte enables for stores |
| p_tlb | input | 3 | Stack-TLB index of the access |
| p_addr | input | 10 | Word address inside the page (bits 11:2) |
| p_wdata | input | 32 | Store data |
| p_ready | output | 1 | Request completes at the next clock edge |
| p_rdata | output | 32 | Load data, valid with ready |
| p_err | output | 1 | Check-code mismatch on a completing load |
| fl_req | input | 1 | Flush request, held until flush-done |
| fl_tlb | input | 3 | TLB index whose lines are flushed |
| fl_done | output | 1 | Single-cycle flush completion pulse |
| m_req | output | 1 | Memory transaction request |
| m_we | output | 1 | 1 = write-back, 0 = fill |
| m_addr | output | 13 | Word address {TLB index, page word address} |
| m_wdata | output | 32 | Write-back data |
| m_rdata | input | 32 | Fill data, valid with acknowledge |
| m_ack | input | 1 | Memory acknowledge, one cycle |

## Verification
Full-word stores to untouched words check that allocation needs no fill. Loads of neighbouring words show that only the missing word is fetched. A sweep over all fourteen partial byte-enable patterns on one word separates a correct lane merge from a swapped or dropped lane. A partial store to an invalid word tells the fill-then-merge path apart from a plain merge. An access with a second TLB index on an occupied line shows that only dirty words are written back, with the right contents. A flush that mixes two indices, including the last line of the cache, shows that only the named index is written back and dropped.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MERGE,
    ST_FILL,
    ST_WB,
    ST_SCAN
  } stk_state_e;

  // one even-parity bit per byte lane
  function automatic logic [3:0] chk_code(input logic [31:0] w);
    logic [3:0] c;
    for (int i = 0; i < 4; i++) c[i] = ^w[8*i +: 8];
    return c;
  endfunction

  function automatic logic [31:0] byte_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = be[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
    return r;
  endfunction

endpackage

// File: rtl/stk_tag_store.sv
module stk_tag_store #(
  parameter int LINES = 128,
  parameter int WPL   = 8,
  parameter int TW    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(LINES)-1:0]   line,
  output logic [TW-1:0]              tag_o,
  output logic [WPL-1:0]             vld_o,
  output logic [WPL-1:0]             dty_o,
  input  logic                       set_en,
  input  logic [$clog2(WPL)-1:0]     set_word,
  input  logic [TW-1:0]              set_tag,
  input  logic                       set_dirty,
  input  logic                       clr_en,
  input  logic [$clog2(WPL)-1:0]     clr_word,
  input  logic                       inv_en
);

  logic [TW-1:0]  tag_q [LINES];
  logic [WPL-1:0] vld_q [LINES];
  logic [WPL-1:0] dty_q [LINES];

  assign tag_o = tag_q[line];
  assign vld_o = vld_q[line];
  assign dty_o = dty_q[line];

  // sector state: invalidate wins over set, set and clear may share a cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        vld_q[i] <= '0;
        dty_q[i] <= '0;
      end
    end else if (inv_en) begin
      vld_q[line] <= '0;
      dty_q[line] <= '0;
    end else begin
      if (set_en) begin
        vld_q[line][set_word] <= 1'b1;
        if (set_dirty) dty_q[line][set_word] <= 1'b1;
      end
      if (clr_en) dty_q[line][clr_word] <= 1'b0;
    end
  end

  // tags need no reset: they are qualified by the valid bits
  always_ff @(posedge clk) begin
    if (set_en) tag_q[line] <= set_tag;
  end

  AST_DIRTY_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (dty_o & ~vld_o) == '0); // R1

endmodule

// File: rtl/stk_word_store.sv
module stk_word_store #(
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [31:0]              wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [31:0]              rdata,
  output logic                     err
);
  import stk_pkg::*;

  logic [31:0] data_q [DEPTH];
  logic [3:0]  code_q [DEPTH];

  // check code is regenerated on every write, merged or not
  always_ff @(posedge clk) begin
    if (we) begin
      data_q[waddr] <= wdata;
      code_q[waddr] <= chk_code(wdata);
    end
  end

  assign rdata = data_q[raddr];
  assign err   = code_q[raddr] != chk_code(data_q[raddr]);

endmodule

// File: rtl/stk_wb_cache.sv
module stk_wb_cache #(
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 32,
  parameter int TLB_ENTRIES = 8
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         p_req,
  input  logic                                         p_we,
  input  logic [3:0]                                   p_be,
  input  logic [$clog2(TLB_ENTRIES)-1:0]               p_tlb,
  input  logic [$clog2(CACHE_BYTES)-1:2]               p_addr,
  input  logic [31:0]                                  p_wdata,
  output logic                                         p_ready,
  output logic [31:0]                                  p_rdata,
  output logic                                         p_err,
  input  logic                                         fl_req,
  input  logic [$clog2(TLB_ENTRIES)-1:0]               fl_tlb,
  output logic                                         fl_done,
  output logic                                         m_req,
  output logic                                         m_we,
  output logic [$clog2(TLB_ENTRIES)+$clog2(CACHE_BYTES)-1:2] m_addr,
  output logic [31:0]                                  m_wdata,
  input  logic [31:0]                                  m_rdata,
  input  logic                                         m_ack
);
  import stk_pkg::*;

  localparam int WPL   = LINE_BYTES / 4;
  localparam int LINES = CACHE_BYTES / LINE_BYTES;
  localparam int WW    = $clog2(WPL);
  localparam int LW    = $clog2(LINES);
  localparam int TW    = $clog2(TLB_ENTRIES);
  localparam logic [WW-1:0] SEC_LAST  = WW'(WPL - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  stk_state_e     state_q, state_d;
  logic [WW-1:0]  sec_q, sec_d;
  logic [LW-1:0]  scan_q, scan_d;
  logic           ret_q, ret_d;
  logic [TW-1:0]  fidx_q, fidx_d;
  logic [31:0]    merge_q, merge_d;

  logic [LW-1:0]  req_line, cur_line;
  logic [WW-1:0]  req_word;
  logic [TW-1:0]  t_tag;
  logic [WPL-1:0] t_vld, t_dty;
  logic           t_used, line_ok, word_vld;
  logic           t_set, t_dirty, t_clr, t_inv;
  logic           w_en, rd_ok, d_err;
  logic [31:0]    w_data, d_rdata;
  logic [LW+WW-1:0] rd_addr;

  assign req_word = p_addr[WW+1:2];
  assign req_line = p_addr[LW+WW+1:WW+2];
  assign cur_line = (state_q == ST_SCAN || (state_q == ST_WB && ret_q)) ? scan_q : req_line;
  assign rd_addr  = (state_q == ST_WB) ? {cur_line, sec_q} : {req_line, req_word};

  stk_tag_store #(.LINES(LINES), .WPL(WPL), .TW(TW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .line     (cur_line),
    .tag_o    (t_tag),
    .vld_o    (t_vld),
    .dty_o    (t_dty),
    .set_en   (t_set),
    .set_word (req_word),
    .set_tag  (p_tlb),
    .set_dirty(t_dirty),
    .clr_en   (t_clr),
    .clr_word (sec_q),
    .inv_en   (t_inv)
  );

  stk_word_store #(.DEPTH(LINES * WPL)) u_words (
    .clk  (clk),
    .we   (w_en),
    .waddr({req_line, req_word}),
    .wdata(w_data),
    .raddr(rd_addr),
    .rdata(d_rdata),
    .err  (d_err)
  );

  assign t_used   = |t_vld;
  assign line_ok  = !t_used || (t_tag == p_tlb);
  assign word_vld = t_vld[req_word];
  assign p_rdata  = d_rdata;
  assign p_err    = rd_ok && d_err;

  always_comb begin
    state_d = state_q;
    sec_d   = sec_q;
    scan_d  = scan_q;
    ret_d   = ret_q;
    fidx_d  = fidx_q;
    merge_d = merge_q;
    p_ready = 1'b0;
    rd_ok   = 1'b0;
    fl_done = 1'b0;
    m_req   = 1'b0;
    m_we    = 1'b0;
    m_addr  = {p_tlb, req_line, req_word};
    m_wdata = d_rdata;
    w_en    = 1'b0;
    w_data  = p_wdata;
    t_set   = 1'b0;
    t_dirty = 1'b0;
    t_clr   = 1'b0;
    t_inv   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fl_req) begin
          state_d = ST_SCAN;
          scan_d  = '0;
          fidx_d  = fl_tlb;
        end else if (p_req) begin
          if (!line_ok) begin
            state_d = ST_WB;
            sec_d   = '0;
            ret_d   = 1'b0;
          end else if (!p_we) begin
            if (word_vld) begin
              p_ready = 1'b1;
              rd_ok   = 1'b1;
            end else begin
              state_d = ST_FILL;
            end
          end else if (&p_be) begin
            p_ready = 1'b1;
            w_en    = 1'b1;
            t_set   = 1'b1;
            t_dirty = 1'b1;
          end else if (word_vld) begin
            merge_d = byte_merge(d_rdata, p_wdata, p_be);
            state_d = ST_MERGE;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_MERGE: begin
        p_ready = 1'b1;
        w_en    = 1'b1;
        w_data  = merge_q;
        t_set   = 1'b1;
        t_dirty = 1'b1;
        state_d = ST_IDLE;
      end
      ST_FILL: begin
        m_req = 1'b1;
        if (m_ack) begin
          w_en    = 1'b1;
          w_data  = m_rdata;
          t_set   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WB: begin
        m_addr = {t_tag, cur_line, sec_q};
        if (t_dty[sec_q]) begin
          m_req = 1'b1;
          m_we  = 1'b1;
        end
        if (!t_dty[sec_q] || m_ack) begin
          t_clr = t_dty[sec_q];
          if (sec_q == SEC_LAST) begin
            t_inv   = 1'b1;
            state_d = ret_q ? ST_SCAN : ST_IDLE;
          end else begin
            sec_d = sec_q + 1'b1;
          end
        end
      end
      ST_SCAN: begin
        if (t_used && t_tag == fidx_q) begin
          state_d = ST_WB;
          sec_d   = '0;
          ret_d   = 1'b1;
        end else if (scan_q == LINE_LAST) begin
          fl_done = 1'b1;
          state_d = ST_IDLE;
        end else begin
          scan_d = scan_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      sec_q   <= '0;
      scan_q  <= '0;
      ret_q   <= 1'b0;
      fidx_q  <= '0;
      merge_q <= '0;
    end else begin
      state_q <= state_d;
      sec_q   <= sec_d;
      scan_q  <= scan_d;
      ret_q   <= ret_d;
      fidx_q  <= fidx_d;
      merge_q <= merge_d;
    end
  end

  AST_FULL_NO_FILL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (p_req && p_we && (&p_be)) |-> !(m_req && !m_we)); // R2

  AST_MERGE_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_MERGE) |=> (state_q == ST_IDLE)); // R3

  AST_FILL_ONLY_INVALID: assert property (@(posedge clk) disable iff (!rst_i_n)
    (m_req && !m_we) |-> !t_vld[req_word]); // R5

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we))); // R6

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    fl_done |=> !fl_done); // R7

  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_i_n)
    (p_req && !p_we && p_ready) |-> !p_err); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_i_n)
    m_req |-> !p_ready); // R9

endmodule

// File: tb/stk_wb_cache_tb.sv
`timescale 1ns/1ps
module stk_wb_cache_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        p_req, p_we, p_ready, p_err;
  logic [3:0]  p_be;
  logic [2:0]  p_tlb, fl_tlb;
  logic [11:2] p_addr;
  logic [31:0] p_wdata, p_rdata;
  logic        fl_req, fl_done;
  logic        m_req, m_we, m_ack;
  logic [14:2] m_addr;
  logic [31:0] m_wdata, m_rdata;

  int total = 0;
  int bad   = 0;
  int n_rd  = 0;
  int n_wr  = 0;

  logic [31:0] bmem   [int];
  logic [31:0] shadow [int];
  logic [31:0] exp_q  [$];

  always #2.5 clk = ~clk;

  stk_wb_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .p_req(p_req), .p_we(p_we), .p_be(p_be), .p_tlb(p_tlb), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_ready(p_ready), .p_rdata(p_rdata), .p_err(p_err),
    .fl_req(fl_req), .fl_tlb(fl_tlb), .fl_done(fl_done),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack)
  );

  function automatic logic [31:0] mdef(input int k);
    logic [31:0] kk;
    kk = k;
    return (kk * 32'h0100_0193) ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] mm_get(input int k);
    return bmem.exists(k) ? bmem[k] : mdef(k);
  endfunction

  function automatic logic [31:0] sh_get(input int k);
    return shadow.exists(k) ? shadow[k] : mdef(k);
  endfunction

  function automatic int key(input logic [2:0] t, input logic [11:0] ofs);
    return int'({t, ofs[11:2]});
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model: one-cycle acknowledge, counts reads and writes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack   <= 1'b0;
      m_rdata <= '0;
    end else if (m_ack) begin
      m_ack <= 1'b0;
    end else if (m_req) begin
      m_ack <= 1'b1;
      if (m_we) begin
        bmem[int'(m_addr)] = m_wdata;
        n_wr++;
      end else begin
        m_rdata <= mm_get(int'(m_addr));
        n_rd++;
      end
    end
  end

  // scoreboard monitor: pops one expected word per completing load
  always begin
    @(negedge clk);
    #1;
    if (rst_n && p_req && p_ready && !p_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected load", p_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(p_rdata == e, "R8 load data", p_rdata, e);
        chk(!p_err, "R8 error flag", {31'd0, p_err}, 32'd0);
      end
    end
  end

  // driver: pushes expectations, updates the reference, waits for ready
  task automatic access(input logic [2:0] t, input logic [11:0] ofs, input logic we,
                        input logic [3:0] be, input logic [31:0] wd, output int cyc);
    int k;
    k = key(t, ofs);
    @(negedge clk);
    p_req = 1'b1; p_we = we; p_be = be; p_tlb = t; p_addr = ofs[11:2]; p_wdata = wd;
    if (!we) begin
      exp_q.push_back(sh_get(k));
    end else begin
      logic [31:0] o, n;
      o = sh_get(k);
      for (int i = 0; i < 4; i++) n[8*i +: 8] = be[i] ? wd[8*i +: 8] : o[8*i +: 8];
      shadow[k] = n;
    end
    cyc = 1;
    #1;
    while (!p_ready) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    @(posedge clk);
    #1;
    p_req = 1'b0;
  endtask

  task automatic flush(input logic [2:0] t);
    @(negedge clk);
    fl_req = 1'b1; fl_tlb = t;
    #1;
    while (!fl_done) begin
      @(negedge clk);
      #1;
    end
    fl_req = 1'b0;
    @(posedge clk);
    #1;
    @(negedge clk);
    #1;
    chk(!fl_done, "R7 done is one pulse", {31'd0, fl_done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, r0, w0;
    rst_n = 1'b0;
    p_req = 1'b0; p_we = 1'b0; p_be = '0; p_tlb = '0; p_addr = '0; p_wdata = '0;
    fl_req = 1'b0; fl_tlb = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!m_req, "R9 reset: no memory request", {31'd0, m_req}, 32'd0);
    chk(!fl_done, "R7 reset: no flush pulse", {31'd0, fl_done}, 32'd0);
    chk(!p_ready, "R9 reset: not ready without request", {31'd0, p_ready}, 32'd0);

    // R2 R4: full store miss allocates without a fill
    access(3'd1, 12'h040, 1'b1, 4'hF, 32'hDEAD_BEEF, cyc);
    chk(cyc == 1, "R2 full store latency", cyc, 1);
    chk(n_rd == 0, "R2 full store no fill", n_rd, 0);
    // R8 load hit
    access(3'd1, 12'h040, 1'b0, 4'h0, 32'h0, cyc);
    chk(cyc == 1, "R8 load hit latency", cyc, 1);
    // R4 R5: neighbour word is invalid, exactly one fetch
    access(3'd1, 12'h044, 1'b0, 4'h0, 32'h0, cyc);
    chk(n_rd == 1, "R4 neighbour fetches one word", n_rd, 1);
    chk(cyc == 4, "R5 fill latency", cyc, 4);
    access(3'd1, 12'h044, 1'b0, 4'h0, 32'h0, cyc);
    chk(cyc == 1 && n_rd == 1, "R5 filled word hits", cyc, 1);

    // R3: every partial byte-enable pattern on a valid word
    for (int b = 1; b < 15; b++) begin
      access(3'd1, 12'h040, 1'b1, 4'(b), 32'h1111_1111 * b, cyc);
      chk(cyc == 2, "R3 partial store one stall", cyc, 2);
      access(3'd1, 12'h040, 1'b0, 4'h0, 32'h0, cyc);
    end
    chk(n_rd == 1, "R3 merge on valid word needs no fill", n_rd, 1);

    // R3 R5: partial store to an invalid word fills then merges
    access(3'd1, 12'h048, 1'b1, 4'b1000, 32'hAB00_0000, cyc);
    chk(cyc == 5, "R3 fill then merge latency", cyc, 5);
    chk(n_rd == 2, "R5 one word fetched for merge", n_rd, 2);
    access(3'd1, 12'h048, 1'b0, 4'h0, 32'h0, cyc);

    access(3'd1, 12'h04C, 1'b1, 4'hF, 32'h0BAD_F00D, cyc);
    access(3'd1, 12'h050, 1'b1, 4'hF, 32'h1234_5678, cyc);
    chk(n_wr == 0, "R1 no memory write from stores", n_wr, 0);

    // R6: conflicting index on line 2 writes back four dirty words
    w0 = n_wr; r0 = n_rd;
    access(3'd5, 12'h040, 1'b0, 4'h0, 32'h0, cyc);
    chk(n_wr - w0 == 4, "R6 dirty words written back once", n_wr - w0, 4);
    chk(n_rd - r0 == 1, "R6 then one fill", n_rd - r0, 1);
    foreach (shadow[k]) begin
      if (k >= key(3'd1, 12'h040) && k <= key(3'd1, 12'h050))
        chk(mm_get(k) == shadow[k], "R6 written-back contents", mm_get(k), shadow[k]);
    end
    // R6: evict clean line, data returns from memory
    w0 = n_wr; r0 = n_rd;
    access(3'd1, 12'h040, 1'b0, 4'h0, 32'h0, cyc);
    chk(n_wr == w0, "R6 clean eviction writes nothing", n_wr - w0, 0);
    chk(n_rd - r0 == 1, "R6 refetch after eviction", n_rd - r0, 1);

    // R7: flush index 1, index 3 untouched, includes last line
    access(3'd1, 12'h100, 1'b1, 4'hF, 32'hCAFE_0100, cyc);
    access(3'd3, 12'h200, 1'b1, 4'hF, 32'hCAFE_0200, cyc);
    access(3'd1, 12'hFFC, 1'b1, 4'hF, 32'hCAFE_0FFC, cyc);
    access(3'd1, 12'hFF8, 1'b1, 4'b0011, 32'h0000_5A5A, cyc);
    w0 = n_wr;
    flush(3'd1);
    chk(n_wr - w0 == 3, "R7 flush writes dirty words of index", n_wr - w0, 3);
    chk(mm_get(key(3'd1, 12'h100)) == sh_get(key(3'd1, 12'h100)), "R7 flush data",
        mm_get(key(3'd1, 12'h100)), sh_get(key(3'd1, 12'h100)));
    chk(mm_get(key(3'd1, 12'hFFC)) == sh_get(key(3'd1, 12'hFFC)), "R7 flush data last line",
        mm_get(key(3'd1, 12'hFFC)), sh_get(key(3'd1, 12'hFFC)));
    chk(mm_get(key(3'd1, 12'hFF8)) == sh_get(key(3'd1, 12'hFF8)), "R7 flush merged data",
        mm_get(key(3'd1, 12'hFF8)), sh_get(key(3'd1, 12'hFF8)));
    chk(!bmem.exists(key(3'd3, 12'h200)), "R7 other index not written", 32'd0, 32'd0);
    r0 = n_rd;
    access(3'd3, 12'h200, 1'b0, 4'h0, 32'h0, cyc);
    chk(n_rd == r0 && cyc == 1, "R7 other index still cached", n_rd - r0, 0);
    access(3'd1, 12'h100, 1'b0, 4'h0, 32'h0, cyc);
    chk(n_rd - r0 == 1, "R7 flushed line refetched", n_rd - r0, 1);
    access(3'd1, 12'h040, 1'b0, 4'h0, 32'h0, cyc);
    chk(n_rd - r0 == 2, "R7 clean line also dropped", n_rd - r0, 2);
    chk(n_wr - w0 == 3, "R1 no writes outside eviction", n_wr - w0, 3);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all loads returned", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule